// File: doc/BRIEF.md
# Multicycle 32-bit Load/Store Processor Core

The core runs a small 32-bit integer instruction set: word load, word store, five register-to-register operations (add, subtract, bitwise and, bitwise or, signed set-on-less-than), branch-if-equal and an absolute jump. Each instruction is split into a short series of clock steps. The core reuses one memory port for both instructions and data. It uses one adder/logic unit for computing the next address, the branch target, effective addresses and arithmetic. Holding registers carry values from one step to the next: the instruction word, the loaded memory word, both register operands and the last ALU result.

A finite-state controller sequences the steps. Fetch and decode are shared by all instructions. What follows depends on the instruction class, so each class takes its own number of cycles. The memory sits outside the core as a word array. It is read combinationally and written on the rising clock edge.

Top module: `mc_core`

## Requirements
- R1: While reset is high and in the first cycle after it falls, the core drives address 0 with a read and no write; reset puts the program counter at 0 and the controller into its fetch step.
- R2: Every instruction starts with a fetch cycle that drives the program counter onto the memory address. The fetched word is captured, and the program counter advances by 4 through the shared ALU.
- R3: Cycle counts per instruction are 3 for branch and jump, 4 for register-to-register and store, 5 for load, and 2 for an unrecognised opcode.
- R4: A load (opcode 35, bits 31:26) writes the word at address reg[bits 25:21] plus sign-extended bits 15:0 into register bits 20:16.
- R5: A store (opcode 43) writes reg[bits 20:16] to address reg[bits 25:21] plus sign-extended bits 15:0. The write happens in the fourth cycle of the instruction.
- R6: Opcode 0 is register-to-register and writes register bits 15:11. Function code bits 5:0 select the operation: 32 add, 34 subtract, 36 and, 37 or.
- R7: Function code 42 writes 1 when the first operand is less than the second as signed two's-complement values, otherwise 0.
- R8: Branch-if-equal (opcode 4) compares reg[bits 25:21] with reg[bits 20:16]. When they are equal, the next instruction comes from the address of the branch plus 4 plus four times the sign-extended bits 15:0. When they differ, execution falls through.
- R9: A jump (opcode 2) continues at the top 4 bits of the incremented program counter, followed by bits 25:0, followed by two zero bits.
- R10: Register 0 always reads as zero and writes to it are dropped.
- R11: An unrecognised opcode returns to fetch after decode and changes no register, no memory word and no program counter value.
- R12: No cycle both reads and writes memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 32 | Byte address for fetch, load or store |
| mem_re | output | 1 | Memory read in this cycle |
| mem_we | output | 1 | Memory write at the end of this cycle |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Word read combinationally at mem_addr |

## Verification
The program's timeline is derived from the per-class cycle costs. Fetch of an instruction falls on the cycle after the previous instruction's last step. A store's write strobe is due three cycles after its own fetch. The bench builds a table of expected start cycles from those costs and the branch outcomes. It samples the memory port at the falling edge of each cycle, so the address of every fetch and the cycle, address and data of every write are compared with the entry due in exactly that cycle. Register results are made visible by storing them, and skipped instructions are shown by store addresses that are never written.

// File: rtl/mc_pkg.sv
package mc_pkg;

  typedef enum logic [3:0] {
    ST_FETCH, ST_DECODE, ST_MADDR, ST_MRD, ST_MWB,
    ST_MWR, ST_REXE, ST_RWB, ST_BEQ, ST_JMP
  } st_e;

  localparam logic [5:0] OP_REG   = 6'd0;
  localparam logic [5:0] OP_LOAD  = 6'd35;
  localparam logic [5:0] OP_STORE = 6'd43;
  localparam logic [5:0] OP_BEQ   = 6'd4;
  localparam logic [5:0] OP_JUMP  = 6'd2;

  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_AND = 6'd36;
  localparam logic [5:0] FN_OR  = 6'd37;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [1:0] {AOP_ADD, AOP_SUB, AOP_FN} aop_e;
  typedef enum logic [1:0] {BSRC_REG, BSRC_FOUR, BSRC_IMM, BSRC_BR} bsrc_e;
  typedef enum logic [1:0] {PCS_ALU, PCS_TGT, PCS_JMP} pcsrc_e;

  typedef struct packed {
    logic   addr_data;
    logic   mem_re;
    logic   mem_we;
    logic   ir_we;
    logic   pc_we;
    logic   pc_beq;
    pcsrc_e pc_src;
    logic   a_pc;
    bsrc_e  b_src;
    aop_e   aop;
    logic   rf_we;
    logic   rf_rd;
    logic   rf_mem;
  } ctl_t;

endpackage

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  aop_e         aop,
  input  logic [5:0]   funct,
  output logic [W-1:0] y,
  output logic         zero
);

  always_comb begin
    y = '0;
    case (aop)
      AOP_ADD: y = a + b;
      AOP_SUB: y = a - b;
      default: begin
        case (funct)
          FN_ADD:  y = a + b;
          FN_SUB:  y = a - b;
          FN_AND:  y = a & b;
          FN_OR:   y = a | b;
          FN_SLT:  y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
          default: y = '0;
        endcase
      end
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);

  localparam int DEPTH = 1 << AW;

  logic [W-1:0] regs_q [DEPTH];

  // Register 0 is hardwired to zero (R10)
  always_ff @(posedge clk) begin
    if (we && (wa != '0)) regs_q[wa] <= wd;
  end

  assign rd1 = (ra1 == '0) ? '0 : regs_q[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs_q[ra2];

endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opcode,
  output st_e        state,
  output ctl_t       ctl
);

  st_e state_q, state_d;

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_FETCH;
    else     state_q <= state_d;
  end

  always_comb begin
    state_d = ST_FETCH;
    case (state_q)
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: begin
        case (opcode)
          OP_LOAD, OP_STORE: state_d = ST_MADDR;
          OP_REG:            state_d = ST_REXE;
          OP_BEQ:            state_d = ST_BEQ;
          OP_JUMP:           state_d = ST_JMP;
          default:           state_d = ST_FETCH;  // R11
        endcase
      end
      ST_MADDR:  state_d = (opcode == OP_LOAD) ? ST_MRD : ST_MWR;
      ST_MRD:    state_d = ST_MWB;
      ST_REXE:   state_d = ST_RWB;
      default:   state_d = ST_FETCH;
    endcase
  end

  always_comb begin
    ctl = '0;
    case (state_q)
      ST_FETCH: begin
        ctl.mem_re = 1'b1;
        ctl.ir_we  = 1'b1;
        ctl.a_pc   = 1'b1;
        ctl.b_src  = BSRC_FOUR;
        ctl.aop    = AOP_ADD;
        ctl.pc_we  = 1'b1;
        ctl.pc_src = PCS_ALU;
      end
      ST_DECODE: begin
        ctl.a_pc  = 1'b1;
        ctl.b_src = BSRC_BR;
        ctl.aop   = AOP_ADD;
      end
      ST_MADDR: begin
        ctl.b_src = BSRC_IMM;
        ctl.aop   = AOP_ADD;
      end
      ST_MRD: begin
        ctl.addr_data = 1'b1;
        ctl.mem_re    = 1'b1;
      end
      ST_MWB: begin
        ctl.rf_we  = 1'b1;
        ctl.rf_mem = 1'b1;
      end
      ST_MWR: begin
        ctl.addr_data = 1'b1;
        ctl.mem_we    = 1'b1;
      end
      ST_REXE: begin
        ctl.b_src = BSRC_REG;
        ctl.aop   = AOP_FN;
      end
      ST_RWB: begin
        ctl.rf_we = 1'b1;
        ctl.rf_rd = 1'b1;
      end
      ST_BEQ: begin
        ctl.b_src  = BSRC_REG;
        ctl.aop    = AOP_SUB;
        ctl.pc_beq = 1'b1;
        ctl.pc_src = PCS_TGT;
      end
      ST_JMP: begin
        ctl.pc_we  = 1'b1;
        ctl.pc_src = PCS_JMP;
      end
      default: ctl = '0;
    endcase
  end

  assign state = state_q;

endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] mem_addr,
  output logic            mem_re,
  output logic            mem_we,
  output logic [XLEN-1:0] mem_wdata,
  input  logic [XLEN-1:0] mem_rdata
);

  localparam int RAW = 5;
  localparam int IMW = 16;

  logic [XLEN-1:0] pc_q, instr_q, memword_q, opa_q, opb_q, res_q;
  st_e             state_q;
  ctl_t            ctl;

  logic [XLEN-1:0] rd1, rd2, alu_a, alu_b, alu_y, imm_sx, imm_br, pc_nxt, wr_data;
  logic [RAW-1:0]  wr_addr;
  logic            alu_zero, pc_load;

  mc_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .opcode (instr_q[31:26]),
    .state  (state_q),
    .ctl    (ctl)
  );

  assign wr_addr = ctl.rf_rd  ? instr_q[15:11] : instr_q[20:16];
  assign wr_data = ctl.rf_mem ? memword_q : res_q;

  mc_regfile #(.W(XLEN), .AW(RAW)) u_rf (
    .clk (clk),
    .ra1 (instr_q[25:21]),
    .ra2 (instr_q[20:16]),
    .rd1 (rd1),
    .rd2 (rd2),
    .we  (ctl.rf_we),
    .wa  (wr_addr),
    .wd  (wr_data)
  );

  assign imm_sx = {{(XLEN-IMW){instr_q[IMW-1]}}, instr_q[IMW-1:0]};
  assign imm_br = {imm_sx[XLEN-3:0], 2'b00};

  assign alu_a = ctl.a_pc ? pc_q : opa_q;

  always_comb begin
    case (ctl.b_src)
      BSRC_REG:  alu_b = opb_q;
      BSRC_FOUR: alu_b = XLEN'(4);
      BSRC_IMM:  alu_b = imm_sx;
      default:   alu_b = imm_br;
    endcase
  end

  mc_alu #(.W(XLEN)) u_alu (
    .a     (alu_a),
    .b     (alu_b),
    .aop   (ctl.aop),
    .funct (instr_q[5:0]),
    .y     (alu_y),
    .zero  (alu_zero)
  );

  always_comb begin
    case (ctl.pc_src)
      PCS_TGT: pc_nxt = res_q;
      PCS_JMP: pc_nxt = {pc_q[XLEN-1:XLEN-4], instr_q[25:0], 2'b00};
      default: pc_nxt = alu_y;
    endcase
  end

  assign pc_load = ctl.pc_we | (ctl.pc_beq & alu_zero);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q      <= '0;
      instr_q   <= '0;
      memword_q <= '0;
      opa_q     <= '0;
      opb_q     <= '0;
      res_q     <= '0;
    end else begin
      if (ctl.ir_we) instr_q <= mem_rdata;
      if (pc_load)   pc_q    <= pc_nxt;
      memword_q <= mem_rdata;
      opa_q     <= rd1;
      opb_q     <= rd2;
      res_q     <= alu_y;
    end
  end

  assign mem_addr  = ctl.addr_data ? res_q : pc_q;
  assign mem_re    = ctl.mem_re;
  assign mem_we    = ctl.mem_we;
  assign mem_wdata = opb_q;

endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk
  import mc_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        mem_re,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input st_e         state,
  input logic [31:0] pc
);

  p_reset_fetch_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mem_addr == 32'd0 && mem_re && !mem_we));

  p_decode_order_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DECODE) |-> ($past(state) == ST_FETCH));

  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == ST_FETCH && state == ST_DECODE) |-> (pc == $past(pc) + 32'd4));

  p_store_after_addr_r5: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ($past(state) == ST_MADDR));

  p_unknown_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH && $past(state) == ST_DECODE) |-> (pc == $past(pc)));

  p_one_access_r12: assert property (@(posedge clk) disable iff (rst)
    !(mem_re && mem_we));

endmodule

bind mc_core mc_core_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .mem_re   (mem_re),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .state    (state_q),
  .pc       (pc_q)
);

// File: tb/mc_core_test.sv
`timescale 1ns/1ps
module mc_core_test;

  localparam int RUN_CYC = 100;
  localparam int C_BR = 3, C_ST = 4, C_RT = 4, C_LD = 5, C_BAD = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_re, mem_we;

  logic [31:0] ram [0:255];

  int nchecks = 0;
  int nfail   = 0;
  bit done    = 0;

  // execution timeline derived from class costs
  int          n_exec = 0;
  logic [31:0] ex_pc    [0:63];
  int          ex_start [0:63];
  int          t_acc = 0;

  // port log
  logic [31:0] log_addr [0:RUN_CYC];
  logic        log_re   [0:RUN_CYC];
  int          n_wr = 0;
  int          wr_cyc  [0:31];
  logic [31:0] wr_addr [0:31];
  logic [31:0] wr_data [0:31];

  always #2.5 clk = ~clk;

  mc_core uut (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_re    (mem_re),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
  );

  assign mem_rdata = ram[mem_addr[9:2]];

  always @(posedge clk) begin
    if (mem_we) ram[mem_addr[9:2]] <= mem_wdata;
  end

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
  endfunction

  function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  function automatic logic [31:0] enc_j(int tgt);
    return {6'd2, 26'(tgt)};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic add_exec(input logic [31:0] pc, input int cost);
    ex_pc[n_exec]    = pc;
    ex_start[n_exec] = t_acc;
    n_exec++;
    t_acc += cost;
  endtask

  task automatic load_program();
    for (int i = 0; i < 256; i++) ram[i] = 32'h0;
    ram[64] = 32'd5;
    ram[65] = 32'hFFFF_FFFD;
    ram[75] = 32'hDEAD_BEEF;   // 0x12C, only skipped stores target it
    ram[0]  = enc_i(35, 0, 1, 16'h100);   // lw  r1
    ram[1]  = enc_i(35, 0, 2, 16'h104);   // lw  r2
    ram[2]  = enc_r(1, 2, 3, 32);         // add
    ram[3]  = enc_r(1, 2, 4, 34);         // sub
    ram[4]  = enc_r(1, 2, 5, 36);         // and
    ram[5]  = enc_r(1, 2, 6, 37);         // or
    ram[6]  = enc_r(2, 1, 7, 42);         // slt  -3 < 5
    ram[7]  = enc_r(1, 2, 8, 42);         // slt  5 < -3
    ram[8]  = enc_i(4, 1, 2, 5);          // beq not taken
    ram[9]  = enc_i(4, 3, 3, 1);          // beq taken -> 44
    ram[10] = enc_i(43, 0, 1, 16'h12C);   // skipped
    ram[11] = enc_i(43, 0, 3, 16'h110);
    ram[12] = enc_i(43, 0, 4, 16'h114);
    ram[13] = enc_i(43, 0, 5, 16'h118);
    ram[14] = enc_i(43, 0, 6, 16'h11C);
    ram[15] = enc_i(43, 0, 7, 16'h120);
    ram[16] = enc_i(43, 0, 8, 16'h124);
    ram[17] = enc_r(1, 1, 0, 32);         // add r0 (dropped)
    ram[18] = enc_i(43, 0, 0, 16'h128);
    ram[19] = enc_j(21);                  // j 84
    ram[20] = enc_i(43, 0, 1, 16'h12C);   // skipped
    ram[21] = enc_i(63, 0, 1, 16'h77);    // unknown opcode
    ram[22] = enc_i(43, 0, 1, 16'h130);
    ram[23] = enc_j(23);                  // j self

    add_exec(0,  C_LD); add_exec(4,  C_LD);
    add_exec(8,  C_RT); add_exec(12, C_RT); add_exec(16, C_RT);
    add_exec(20, C_RT); add_exec(24, C_RT); add_exec(28, C_RT);
    add_exec(32, C_BR); add_exec(36, C_BR);
    add_exec(44, C_ST); add_exec(48, C_ST); add_exec(52, C_ST);
    add_exec(56, C_ST); add_exec(60, C_ST); add_exec(64, C_ST);
    add_exec(68, C_RT); add_exec(72, C_ST);
    add_exec(76, C_BR); add_exec(84, C_BAD); add_exec(88, C_ST);
    add_exec(92, C_BR); add_exec(92, C_BR);
  endtask

  task automatic run_reset_scenario();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "addr in reset", mem_addr, 32'h0);
    chk("R1", "we in reset", {31'd0, mem_we}, 32'h0);
    rst = 1'b0;
  endtask

  task automatic run_program();
    for (int c = 0; c <= RUN_CYC; c++) begin
      log_addr[c] = mem_addr;
      log_re[c]   = mem_re;
      if (mem_we) begin
        if (n_wr < 32) begin
          wr_cyc[n_wr]  = c;
          wr_addr[n_wr] = mem_addr;
          wr_data[n_wr] = mem_wdata;
        end
        n_wr++;
        if (mem_re) chk("R12", "read and write same cycle", 32'd1, 32'd0);
      end
      @(negedge clk);
    end
  endtask

  task automatic check_first_cycle();
    chk("R1", "first fetch addr", log_addr[0], 32'h0);
    chk("R1", "first fetch read", {31'd0, log_re[0]}, 32'h1);
  endtask

  task automatic check_fetch_timeline();
    // R2 fetch address, R3 cycle costs, R8/R9 control flow
    for (int i = 0; i < n_exec; i++) begin
      chk("R3", $sformatf("fetch %0d addr", i), log_addr[ex_start[i]], ex_pc[i]);
      chk("R2", $sformatf("fetch %0d read", i), {31'd0, log_re[ex_start[i]]}, 32'h1);
    end
  endtask

  task automatic exp_store(input int idx, input int exec_idx, input string req,
                           input logic [31:0] addr, input logic [31:0] data);
    chk("R5", $sformatf("store %0d cycle", idx), 32'(wr_cyc[idx]), 32'(ex_start[exec_idx] + 3));
    chk("R5", $sformatf("store %0d addr", idx), wr_addr[idx], addr);
    chk(req, $sformatf("store %0d data", idx), wr_data[idx], data);
  endtask

  task automatic check_results();
    chk("R8", "write count (skipped stores absent)", 32'(n_wr), 32'd8);
    if (n_wr >= 8) begin
      exp_store(0, 10, "R6", 32'h110, 32'd2);            // add, uses R4 loads
      exp_store(1, 11, "R6", 32'h114, 32'd8);            // sub
      exp_store(2, 12, "R6", 32'h118, 32'd5);            // and
      exp_store(3, 13, "R6", 32'h11C, 32'hFFFF_FFFD);    // or
      exp_store(4, 14, "R7", 32'h120, 32'd1);            // signed less
      exp_store(5, 15, "R7", 32'h124, 32'd0);            // signed not less
      exp_store(6, 17, "R10", 32'h128, 32'd0);           // r0 stays zero
      exp_store(7, 20, "R11", 32'h130, 32'd5);           // r1 untouched
    end
    chk("R4", "loaded r1 via mem", ram[76], 32'd5);
    chk("R9", "skipped word kept", ram[75], 32'hDEAD_BEEF);
  endtask

  initial begin
    load_program();
    run_reset_scenario();
    run_program();
    check_first_cycle();
    check_fetch_timeline();
    check_results();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nchecks++;
      nfail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
    end
  end

endmodule